// File: doc/BRIEF.md
# Layer-Count Pretrigger

This block makes a fast early trigger decision for a chamber built from stacked detector layers. Each bunch crossing, it receives one hit bitmap per layer from the comparators. It reduces each bitmap to one bit that says whether that layer saw anything. It then counts those bits and compares the count with a programmable threshold. It does not look for a hit pattern. Any spread of hits over enough layers in the same crossing is enough, so the decision takes one crossing. An external pattern finder sends a second candidate, the number of layers its best pattern matched. That candidate is compared with its own threshold under its own enable and then merged into the combined pretrigger. Two saturating event counters let software watch the layer-trigger rate and the combined pretrigger rate.

A crossing is presented by raising `in_valid` with the hit bitmaps. The block has no back-pressure: it accepts a crossing on every clock where `in_valid` is high. A crossing without `in_valid` can never fire a trigger. All outputs are registered and appear one clock after the crossing that caused them.

Top module: `layer_pretrigger`

## Requirements
- R1: A layer counts as hit when any bit of its `HITS_PER_LAYER`-bit slice of `layer_hits` is 1. Layer k occupies bits [k*HITS_PER_LAYER +: HITS_PER_LAYER]. `layer_count_o` equals the number of hit layers sampled at the previous clock edge. It updates on every clock, whatever `in_valid` is.
- R2: `layer_trig_o` is never high unless `layer_trig_en` and `in_valid` were both 1 at the previous edge.
- R3: `layer_trig_o` is high for exactly the cycle after a crossing where `in_valid` and `layer_trig_en` are 1 and the unsigned hit-layer count is at least `layer_thresh`. A threshold of 0 fires on every such crossing. A threshold above `NUM_LAYERS` never fires.
- R4: `pat_trig_o` is high for the cycle after a crossing where `in_valid` and `pat_trig_en` are 1 and `pat_layers` is at least `pat_thresh` (unsigned). With six layers, `pat_thresh` = 7 silences this path while the layer path keeps working.
- R5: `pretrig_o` is high in a cycle exactly when `layer_trig_o` or `pat_trig_o` is high in that cycle.
- R6: `layer_evt_o` increments by one at the same edge that raises `layer_trig_o`. `pretrig_evt_o` increments in the same way with `pretrig_o`. The value shown alongside a pulse already includes that event.
- R7: Each event counter is `EVT_W` bits wide and holds at all-ones instead of wrapping.
- R8: When `evt_clr` is 1 at an edge, both counters become 0 at that edge. Clearing wins over an increment in the same cycle and leaves the trigger outputs unchanged.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A crossing is present this cycle |
| layer_hits | input | NUM_LAYERS*HITS_PER_LAYER | Comparator hit bitmaps, layer 0 in the low bits |
| layer_trig_en | input | 1 | Enables the layer-count trigger |
| layer_thresh | input | CW | Minimum number of hit layers |
| pat_trig_en | input | 1 | Enables the pattern candidate path |
| pat_thresh | input | CW | Minimum matched layers for the pattern path |
| pat_layers | input | CW | Matched layer count from the pattern finder |
| evt_clr | input | 1 | Synchronous clear of both event counters |
| layer_count_o | output | CW | Registered count of hit layers |
| layer_trig_o | output | 1 | Layer-count trigger pulse |
| pat_trig_o | output | 1 | Pattern-path trigger pulse |
| pretrig_o | output | 1 | Combined pretrigger pulse |
| layer_evt_o | output | EVT_W | Saturating count of layer triggers |
| pretrig_evt_o | output | EVT_W | Saturating count of combined pretriggers |

CW is $clog2(NUM_LAYERS+1).

## Verification
The bench keeps six layers of 32 hits each, so the count spans 0 to 6. A threshold of 7 then lies beyond any real count, and both the "never fires" case and the disabled pattern path can be tested. The event counters are built with `EVT_W` = 4. That puts saturation within about twenty triggers, so the bench can show the hold at full scale and a clear that lands on a saturated counter. The directed steps place single hits at both ends of each layer slice and sweep every threshold against every layer count. Random crossings then mix enables, thresholds and clears.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  // Width needed to hold a count from 0 to n inclusive.
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lpt_layer_detect.sv
module lpt_layer_detect #(
  parameter int NUM_LAYERS     = 6,
  parameter int HITS_PER_LAYER = 32,
  localparam int HB            = NUM_LAYERS * HITS_PER_LAYER
) (
  input  logic [HB-1:0]         hits,
  output logic [NUM_LAYERS-1:0] layer_any
);

  // One OR-reduction per layer slice.
  for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
    assign layer_any[l] = |hits[l*HITS_PER_LAYER +: HITS_PER_LAYER];
  end

endmodule

// File: rtl/lpt_popcount.sv
module lpt_popcount #(
  parameter int N = 6,
  localparam int W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits,
  output logic [W-1:0] cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + W'(bits[i]);
  end

endmodule

// File: rtl/lpt_sat_counter.sv
module lpt_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);

  localparam logic [W-1:0] FULL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   value <= '0;
    else if (clr)                 value <= '0;
    else if (inc && value != FULL) value <= value + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (value == FULL && !clr) |=> value == FULL); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> value == '0); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (value == $past(value) || value == $past(value) + 1'b1)); // R6

endmodule

// File: rtl/layer_pretrigger.sv
module layer_pretrigger
  import lpt_pkg::*;
#(
  parameter int NUM_LAYERS     = 6,
  parameter int HITS_PER_LAYER = 32,
  parameter int EVT_W          = 32,
  localparam int CW            = $clog2(NUM_LAYERS + 1),
  localparam int HB            = NUM_LAYERS * HITS_PER_LAYER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [HB-1:0]    layer_hits,
  input  logic             layer_trig_en,
  input  logic [CW-1:0]    layer_thresh,
  input  logic             pat_trig_en,
  input  logic [CW-1:0]    pat_thresh,
  input  logic [CW-1:0]    pat_layers,
  input  logic             evt_clr,
  output logic [CW-1:0]    layer_count_o,
  output logic             layer_trig_o,
  output logic             pat_trig_o,
  output logic             pretrig_o,
  output logic [EVT_W-1:0] layer_evt_o,
  output logic [EVT_W-1:0] pretrig_evt_o
);

  localparam int PKG_CW = count_width(NUM_LAYERS);

  logic [NUM_LAYERS-1:0] layer_any;
  logic [PKG_CW-1:0]     hit_cnt;
  logic                  layer_fire, pat_fire, pre_fire;
  logic                  past_ok;

  lpt_layer_detect #(.NUM_LAYERS(NUM_LAYERS), .HITS_PER_LAYER(HITS_PER_LAYER)) u_detect (
    .hits      (layer_hits),
    .layer_any (layer_any)
  );

  lpt_popcount #(.N(NUM_LAYERS)) u_count (
    .bits (layer_any),
    .cnt  (hit_cnt)
  );

  // Same-crossing decisions for both candidates.
  always_comb begin
    layer_fire = in_valid && layer_trig_en && (hit_cnt >= layer_thresh);
    pat_fire   = in_valid && pat_trig_en   && (pat_layers >= pat_thresh);
    pre_fire   = layer_fire || pat_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      layer_count_o <= '0;
      layer_trig_o  <= 1'b0;
      pat_trig_o    <= 1'b0;
      pretrig_o     <= 1'b0;
      past_ok       <= 1'b0;
    end else begin
      layer_count_o <= hit_cnt;
      layer_trig_o  <= layer_fire;
      pat_trig_o    <= pat_fire;
      pretrig_o     <= pre_fire;
      past_ok       <= 1'b1;
    end
  end

  lpt_sat_counter #(.W(EVT_W)) u_layer_evt (
    .clk (clk), .rst_n (rst_n), .clr (evt_clr), .inc (layer_fire), .value (layer_evt_o)
  );

  lpt_sat_counter #(.W(EVT_W)) u_pre_evt (
    .clk (clk), .rst_n (rst_n), .clr (evt_clr), .inc (pre_fire), .value (pretrig_evt_o)
  );

  AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> layer_count_o == CW'($countones($past(layer_any)))); // R1
  AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    layer_trig_o |-> $past(layer_trig_en && in_valid)); // R2
  AST_TRIG_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    layer_trig_o |-> layer_count_o >= $past(layer_thresh)); // R3
  AST_PAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pat_trig_o |-> $past(pat_trig_en && in_valid)); // R4
  AST_PRETRIG_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_trig_o || pat_trig_o) |-> pretrig_o); // R5
  AST_LAYER_EVT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (layer_fire && !evt_clr && layer_evt_o != '1) |=> layer_evt_o == $past(layer_evt_o) + 1'b1); // R6

endmodule

// File: tb/tb_layer_pretrigger.sv
module tb_layer_pretrigger;

  localparam int NL  = 6;
  localparam int HW  = 32;
  localparam int EW  = 4;
  localparam int CW  = $clog2(NL + 1);
  localparam int HB  = NL * HW;
  localparam int MAXE = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [HB-1:0] layer_hits = '0;
  logic layer_trig_en = 1'b0;
  logic [CW-1:0] layer_thresh = '0;
  logic pat_trig_en = 1'b0;
  logic [CW-1:0] pat_thresh = '0;
  logic [CW-1:0] pat_layers = '0;
  logic evt_clr = 1'b0;
  logic [CW-1:0] layer_count_o;
  logic layer_trig_o, pat_trig_o, pretrig_o;
  logic [EW-1:0] layer_evt_o, pretrig_evt_o;

  always #4 clk = ~clk;

  layer_pretrigger #(.NUM_LAYERS(NL), .HITS_PER_LAYER(HW), .EVT_W(EW)) dut (
    .clk, .rst_n, .in_valid, .layer_hits, .layer_trig_en, .layer_thresh,
    .pat_trig_en, .pat_thresh, .pat_layers, .evt_clr, .layer_count_o,
    .layer_trig_o, .pat_trig_o, .pretrig_o, .layer_evt_o, .pretrig_evt_o
  );

  int n_checks = 0;
  int n_err = 0;
  bit chk_en = 0;
  bit done = 0;

  // Behavioural reference.
  int e_cnt = 0, e_lt = 0, e_pt = 0, e_pre = 0, e_lev = 0, e_pev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_cnt = 0; e_lt = 0; e_pt = 0; e_pre = 0; e_lev = 0; e_pev = 0;
    end else begin
      int n;
      bit lf, pf;
      n = 0;
      for (int l = 0; l < NL; l++) if (layer_hits[l*HW +: HW] != 0) n++;
      lf = in_valid && layer_trig_en && (n >= int'(layer_thresh));
      pf = in_valid && pat_trig_en && (int'(pat_layers) >= int'(pat_thresh));
      e_cnt = n; e_lt = lf; e_pt = pf; e_pre = lf || pf;
      if (evt_clr) begin e_lev = 0; e_pev = 0; end
      else begin
        if (lf && e_lev < MAXE) e_lev++;
        if ((lf || pf) && e_pev < MAXE) e_pev++;
      end
    end
  end

  task automatic chk(string req, string nm, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_en && !done) begin
    chk("R1", "layer_count_o", longint'(layer_count_o), e_cnt);
    chk("R2 R3", "layer_trig_o", longint'(layer_trig_o), e_lt);
    chk("R4", "pat_trig_o", longint'(pat_trig_o), e_pt);
    chk("R5", "pretrig_o", longint'(pretrig_o), e_pre);
    chk("R6 R7 R8", "layer_evt_o", longint'(layer_evt_o), e_lev);
    chk("R6 R7 R8", "pretrig_evt_o", longint'(pretrig_evt_o), e_pev);
  end

  function automatic logic [HB-1:0] mk(int mask, int pos);
    logic [HB-1:0] h = '0;
    for (int l = 0; l < NL; l++) if (mask[l]) h[l*HW + pos] = 1'b1;
    return h;
  endfunction

  task automatic drive(bit v, logic [HB-1:0] h, bit le, int lt, bit pe, int pt, int pl, bit clr);
    @(negedge clk); #1;
    in_valid = v; layer_hits = h; layer_trig_en = le; layer_thresh = CW'(lt);
    pat_trig_en = pe; pat_thresh = CW'(pt); pat_layers = CW'(pl); evt_clr = clr;
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    chk_en = 1;
    @(negedge clk);
    // R9: outputs zero while reset is held
    chk("R9", "reset layer_trig_o", longint'(layer_trig_o), 0);
    chk("R9", "reset pretrig_o", longint'(pretrig_o), 0);
    chk("R9", "reset layer_evt_o", longint'(layer_evt_o), 0);
    #1 rst_n = 1'b1;

    // R1 R3: every threshold against every layer count, hits at slice ends
    for (int t = 0; t <= 7; t++)
      for (int k = 0; k <= NL; k++)
        drive(1, mk((1 << k) - 1, (k % 2) ? HW - 1 : 0), 1, t, 0, 7, 6, 0);
    // R1: single upper layers only
    for (int l = 0; l < NL; l++) drive(1, mk(1 << l, HW - 1), 1, 1, 0, 0, 0, 0);
    // R2: enable clear, all layers hit
    drive(1, mk(6'h3f, 5), 0, 1, 0, 0, 0, 0);
    // R2: no valid crossing
    drive(0, mk(6'h3f, 5), 1, 1, 0, 0, 0, 0);
    // R4: pattern path alone, threshold 7 silences it
    for (int t = 0; t <= 7; t++) drive(1, '0, 0, 0, 1, t, 6, 0);
    drive(1, mk(6'h03, 0), 1, 2, 1, 7, 6, 0);  // layer fires, pattern silent
    // R7: saturate the counters
    for (int i = 0; i < 20; i++) drive(1, mk(6'h0f, i % HW), 1, 2, 0, 7, 0, 0);
    // R8: clear on a firing crossing
    drive(1, mk(6'h0f, 3), 1, 2, 1, 1, 2, 1);
    drive(1, mk(6'h0f, 3), 1, 2, 0, 1, 2, 0);
    // R9: asynchronous reset in the middle of activity
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;

    for (int i = 0; i < 2000; i++) begin
      logic [HB-1:0] h = '0;
      for (int l = 0; l < NL; l++) begin
        int r = $urandom % 4;
        if (r == 2) h[l*HW + ($urandom % HW)] = 1'b1;
        else if (r == 3) h[l*HW +: HW] = HW'($urandom);
      end
      drive($urandom % 8 != 0, h, $urandom % 4 != 0, $urandom % 8,
            $urandom % 2, $urandom % 8, $urandom % 7, $urandom % 50 == 0);
    end
    drive(0, '0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #2;
    summary();
  end

endmodule